// File: doc/BRIEF.md
# Pipelined Burst SRAM Behavioural Model

This block is a synthesizable model of a synchronous static RAM whose read path is pipelined and whose address can run through a short burst on its own. Each word holds four byte lanes. A lane is eight data bits plus one parity bit. A cycle is opened by one of two start strobes. The processor strobe is qualified by the enable input. The controller strobe acts whenever it is low. On later cycles the block continues the burst: it steps to the next word or stays on the current one, in linear or interleaved order.

Writes may cover the whole word through a global write input. They may instead cover selected lanes through a lane-enable input and four lane selects. Read data leaves through a register one clock after the address is taken, and a registered valid flag goes with it. A drive indication stands in for the tristate pads. It is asserted only when valid data is held, the asynchronous output enable is low and no write occurs in the current cycle. While the sleep input is high, every register and every memory word keeps its value.

Top module: `bsram_model`

## Requirements
- R1: The block is selected only when `en_n`=0, `sel_hi`=1 and `sel_lo_n`=0. A start strobe seen while the block is not selected ends any burst and performs no access. `rd_valid` is then low after the next edge.
- R2: A low `proc_start_n` counts as a start only while `en_n`=0. A low `ctrl_start_n` counts as a start regardless of `en_n`. A selected start loads `addr` as the cycle address.
- R3: A cycle opened by the processor strobe is always a read. On that edge `all_wr_n`, `lane_wr_en_n` and `lane_sel_n` change no stored word.
- R4: A write cycle with `all_wr_n`=0 stores all four lanes, whatever `lane_wr_en_n` and `lane_sel_n` hold.
- R5: When `all_wr_n`=1 and `lane_wr_en_n`=0, each lane k (k = 0..3) with `lane_sel_n[k]`=0 is written. Several lanes may be written in one cycle. Lane k is `wr_data[8k+7:8k]` together with `wr_par[k]`. When `lane_wr_en_n`=1, the lane selects are ignored and the cycle is a read.
- R6: A read cycle at the edge n sets `rd_valid` high after edge n+1, with `rd_data` and `rd_par` holding that word. A write to the same word at edge n+1 does not alter the value shown.
- R7: During a burst, a cycle with both start strobes high and `step_n`=0 advances an offset counter modulo 4. With `seq_interleave`=0 the word is the base address with its two low bits replaced by (base + offset) mod 4. With `seq_interleave`=1 those bits are base XOR offset. After four steps the counter wraps back to the base word.
- R8: During a burst, a cycle with both start strobes high and `step_n`=1 reuses the current word, for a read or for a write.
- R9: `out_drive` is high exactly when `rd_valid`=1, `out_en_n`=0, `sleep`=0 and the current cycle does not write.
- R10: While `sleep`=1, no register and no stored word changes, and `rd_valid`, `rd_data` and `rd_par` hold their values.
- R11: After reset, `rd_valid`=0, `out_drive`=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | High freezes all state |
| addr | input | 8 | External word address |
| proc_start_n | input | 1 | Processor start strobe, active low, qualified by en_n |
| ctrl_start_n | input | 1 | Controller start strobe, active low |
| en_n | input | 1 | Enable, active low |
| sel_hi | input | 1 | Select, active high |
| sel_lo_n | input | 1 | Select, active low |
| step_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Whole-word write, active low |
| lane_wr_en_n | input | 1 | Lane write qualifier, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| seq_interleave | input | 1 | 1 = interleaved burst order, 0 = linear |
| wr_data | input | 32 | Write data, eight bits per lane |
| wr_par | input | 4 | Write parity, one bit per lane |
| rd_data | output | 32 | Registered read data |
| rd_par | output | 4 | Registered read parity |
| rd_valid | output | 1 | Registered read data is valid |
| out_drive | output | 1 | Read data would be driven onto the bus |

## Verification
Before any check, the whole array is filled through controller-started global writes, so every later read has a known value. Directed sequences follow. They run bursts from every low-address offset in both orders, with and without suspension, which separates the linear order from the XOR order and separates advance from hold. They also write with lane masks that leave gaps, which shows whether each lane gets its own bits and parity, and they write through the processor strobe, which shows whether writes are taken on the start edge or only on the edge after it. Further sequences try deselection through each select input and the gating of the processor strobe by enable, and enter sleep in the middle of a burst. Long runs of seeded random strobes, selects and write controls are then checked against a reference array, cycle by cycle.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   // Kind of access performed in the current cycle
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2
   } cyc_kind_e;

   // Decoded start information for one cycle
   typedef struct packed {
      logic load;     // selected start: take external address
      logic drop;     // start while unselected: end burst
      logic proc_go;  // processor strobe qualified by enable
   } start_t;

endpackage

// File: rtl/bsram_cmd_decode.sv
module bsram_cmd_decode
   import bsram_pkg::*;
#(
   parameter int unsigned LANES = 4
) (
   input  logic             en_n,
   input  logic             sel_hi,
   input  logic             sel_lo_n,
   input  logic             proc_start_n,
   input  logic             ctrl_start_n,
   input  logic             all_wr_n,
   input  logic             lane_wr_en_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             burst_live,
   output start_t           start,
   output cyc_kind_e        kind,
   output logic [LANES-1:0] lane_we
);

   logic             selected;
   logic             any_start;
   logic [LANES-1:0] req_mask;

   always_comb begin
      selected      = !en_n && sel_hi && !sel_lo_n;
      start.proc_go = !proc_start_n && !en_n;
      any_start     = start.proc_go || !ctrl_start_n;
      start.load    = any_start && selected;
      start.drop    = any_start && !selected;
   end

   // whole-word write dominates; lane selects only pass when qualified
   always_comb begin
      if (!all_wr_n)
         req_mask = '1;
      else if (!lane_wr_en_n)
         req_mask = ~lane_sel_n;
      else
         req_mask = '0;
   end

   always_comb begin
      kind = CYC_IDLE;
      if (start.load) begin
         if (start.proc_go)
            kind = CYC_READ;
         else if (|req_mask)
            kind = CYC_WRITE;
         else
            kind = CYC_READ;
      end else if (start.drop) begin
         kind = CYC_IDLE;
      end else if (burst_live) begin
         kind = (|req_mask) ? CYC_WRITE : CYC_READ;
      end
   end

   assign lane_we = (kind == CYC_WRITE) ? req_mask : '0;

endmodule

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq #(
   parameter int unsigned AW        = 8,
   parameter int unsigned BURST_LEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          load,
   input  logic          drop,
   input  logic          step,
   input  logic          interleave,
   input  logic [AW-1:0] ext_addr,
   output logic [AW-1:0] cyc_addr,
   output logic          live
);

   localparam int unsigned CW = $clog2(BURST_LEN);

   logic [AW-1:0] base_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;
   logic [CW-1:0] low_bits;
   logic          live_q;

   assign cnt_nxt = step ? cnt_q + 1'b1 : cnt_q;

   always_comb begin
      if (interleave)
         low_bits = base_q[CW-1:0] ^ cnt_nxt;
      else
         low_bits = base_q[CW-1:0] + cnt_nxt;
   end

   generate
      if (AW > CW) begin : g_upper
         assign cyc_addr = load ? ext_addr : {base_q[AW-1:CW], low_bits};
      end else begin : g_flat
         assign cyc_addr = load ? ext_addr : low_bits;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         live_q <= 1'b0;
      end else if (run) begin
         if (load) begin
            base_q <= ext_addr;
            cnt_q  <= '0;
            live_q <= 1'b1;
         end else if (drop) begin
            live_q <= 1'b0;
         end else if (live_q) begin
            cnt_q <= cnt_nxt;
         end
      end
   end

   assign live = live_q;

endmodule

// File: rtl/bsram_lane_array.sv
module bsram_lane_array #(
   parameter int unsigned DEPTH  = 256,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 9
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic [LANES-1:0]          we,
   input  logic [$clog2(DEPTH)-1:0]  cyc_addr,
   input  logic [LANES*LANE_W-1:0]   wr_word,
   input  logic                      rd_req,
   output logic [LANES*LANE_W-1:0]   rd_word,
   output logic                      rd_valid
);

   localparam int unsigned AW = $clog2(DEPTH);

   logic          pend_q;
   logic [AW-1:0] paddr_q;
   logic          valid_q;

   // address stage of the read pipeline
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         paddr_q <= '0;
         valid_q <= 1'b0;
      end else if (run) begin
         pend_q  <= rd_req;
         paddr_q <= cyc_addr;
         valid_q <= pend_q;
      end
   end

   assign rd_valid = valid_q;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] mem [DEPTH];
         logic [LANE_W-1:0] dout_q;

         always_ff @(posedge clk) begin
            if (run && we[g])
               mem[cyc_addr] <= wr_word[g*LANE_W +: LANE_W];
         end

         always_ff @(posedge clk) begin
            if (!rst_n)
               dout_q <= '0;
            else if (run && pend_q)
               dout_q <= mem[paddr_q];
         end

         assign rd_word[g*LANE_W +: LANE_W] = dout_q;
      end
   endgenerate

endmodule

// File: rtl/bsram_model.sv
module bsram_model
   import bsram_pkg::*;
#(
   parameter int unsigned DEPTH     = 256,
   parameter int unsigned LANES     = 4,
   parameter int unsigned LANE_DATA = 8,
   parameter int unsigned BURST_LEN = 4,
   localparam int unsigned AW       = $clog2(DEPTH),
   localparam int unsigned DW       = LANES * LANE_DATA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep,
   input  logic [AW-1:0]    addr,
   input  logic             proc_start_n,
   input  logic             ctrl_start_n,
   input  logic             en_n,
   input  logic             sel_hi,
   input  logic             sel_lo_n,
   input  logic             step_n,
   input  logic             all_wr_n,
   input  logic             lane_wr_en_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             out_en_n,
   input  logic             seq_interleave,
   input  logic [DW-1:0]    wr_data,
   input  logic [LANES-1:0] wr_par,
   output logic [DW-1:0]    rd_data,
   output logic [LANES-1:0] rd_par,
   output logic             rd_valid,
   output logic             out_drive
);

   localparam int unsigned LANE_W = LANE_DATA + 1;
   localparam int unsigned WW     = LANES * LANE_W;

   // elaboration-time parameter checks
   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < BURST_LEN) begin : g_bad_depth
         $error("bsram_model: DEPTH must be a power of two and at least BURST_LEN");
      end
      if ((BURST_LEN & (BURST_LEN - 1)) != 0 || BURST_LEN < 2) begin : g_bad_burst
         $error("bsram_model: BURST_LEN must be a power of two of at least 2");
      end
      if (LANES < 1 || LANE_DATA < 1) begin : g_bad_lane
         $error("bsram_model: LANES and LANE_DATA must be non-zero");
      end
   endgenerate

   logic             run;
   start_t           start;
   cyc_kind_e        kind;
   logic [LANES-1:0] lane_we;
   logic             burst_live;
   logic [AW-1:0]    cyc_addr;
   logic [WW-1:0]    wr_word;
   logic [WW-1:0]    rd_word;

   assign run = !sleep;

   bsram_cmd_decode #(
      .LANES(LANES)
   ) u_dec (
      .en_n         (en_n),
      .sel_hi       (sel_hi),
      .sel_lo_n     (sel_lo_n),
      .proc_start_n (proc_start_n),
      .ctrl_start_n (ctrl_start_n),
      .all_wr_n     (all_wr_n),
      .lane_wr_en_n (lane_wr_en_n),
      .lane_sel_n   (lane_sel_n),
      .burst_live   (burst_live),
      .start        (start),
      .kind         (kind),
      .lane_we      (lane_we)
   );

   bsram_burst_seq #(
      .AW        (AW),
      .BURST_LEN (BURST_LEN)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .load       (start.load),
      .drop       (start.drop),
      .step       (!step_n),
      .interleave (seq_interleave),
      .ext_addr   (addr),
      .cyc_addr   (cyc_addr),
      .live       (burst_live)
   );

   bsram_lane_array #(
      .DEPTH  (DEPTH),
      .LANES  (LANES),
      .LANE_W (LANE_W)
   ) u_arr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .we       (lane_we),
      .cyc_addr (cyc_addr),
      .wr_word  (wr_word),
      .rd_req   (kind == CYC_READ),
      .rd_word  (rd_word),
      .rd_valid (rd_valid)
   );

   // lane k = {parity bit k, data byte k}
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_pack
         assign wr_word[g*LANE_W +: LANE_W]     = {wr_par[g], wr_data[g*LANE_DATA +: LANE_DATA]};
         assign rd_data[g*LANE_DATA +: LANE_DATA] = rd_word[g*LANE_W +: LANE_DATA];
         assign rd_par[g]                       = rd_word[g*LANE_W + LANE_DATA];
      end
   endgenerate

   assign out_drive = rd_valid && !out_en_n && !sleep && (kind != CYC_WRITE);

endmodule

// File: rtl/bsram_model_chk.sv
module bsram_model_chk
   import bsram_pkg::*;
#(
   parameter int unsigned LANES = 4,
   parameter int unsigned WW    = 36
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sleep,
   input start_t           start,
   input cyc_kind_e        kind,
   input logic [LANES-1:0] lane_we,
   input logic             all_wr_n,
   input logic             out_en_n,
   input logic             out_drive,
   input logic             rd_valid,
   input logic [WW-1:0]    rd_word
);

   // R1
   deselect_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && start.drop) ##1 !sleep |=> !rd_valid);

   // R3
   proc_start_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start.proc_go |-> (lane_we == '0));

   // R4
   global_write_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == CYC_WRITE && !all_wr_n) |-> (&lane_we));

   // R6
   read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleep && kind == CYC_READ) ##1 !sleep |=> rd_valid);

   // R9
   oe_high_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_n |-> !out_drive);

   // R10
   sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> ($stable(rd_valid) && $stable(rd_word)));

endmodule

bind bsram_model bsram_model_chk #(
   .LANES (LANES),
   .WW    (LANES * (LANE_DATA + 1))
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep     (sleep),
   .start     (start),
   .kind      (kind),
   .lane_we   (lane_we),
   .all_wr_n  (all_wr_n),
   .out_en_n  (out_en_n),
   .out_drive (out_drive),
   .rd_valid  (rd_valid),
   .rd_word   (rd_word)
);

// File: tb/sim_bsram_model.sv
`timescale 1ns/1ps
module sim_bsram_model;

   localparam int DEPTH = 256;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sleep;
   logic [7:0]  addr;
   logic        ps_n, cs_n, en_n, shi, slo_n, step_n;
   logic        gw_n, bwe_n;
   logic [3:0]  bw_n;
   logic        oe_n, ilv;
   logic [31:0] wd;
   logic [3:0]  wp;
   logic [31:0] rd_data;
   logic [3:0]  rd_par;
   logic        rd_valid, out_drive;

   always #2 clk = ~clk;   // 250 MHz

   bsram_model u0 (
      .clk (clk), .rst_n (rst_n), .sleep (sleep), .addr (addr),
      .proc_start_n (ps_n), .ctrl_start_n (cs_n), .en_n (en_n),
      .sel_hi (shi), .sel_lo_n (slo_n), .step_n (step_n),
      .all_wr_n (gw_n), .lane_wr_en_n (bwe_n), .lane_sel_n (bw_n),
      .out_en_n (oe_n), .seq_interleave (ilv), .wr_data (wd), .wr_par (wp),
      .rd_data (rd_data), .rd_par (rd_par), .rd_valid (rd_valid), .out_drive (out_drive)
   );

   // reference state
   logic [31:0] ref_d [DEPTH];
   logic [3:0]  ref_p [DEPTH];
   logic [7:0]  m_base, m_paddr;
   logic [1:0]  m_cnt;
   logic        m_act, m_pend;
   logic        e_valid;
   logic [31:0] e_d;
   logic [3:0]  e_p;

   int    n_chk = 0, n_bad = 0;
   string tag = "R11";

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
      end
   endtask

   // evaluate the cycle the current inputs describe (0 idle, 1 read, 2 write)
   task automatic mdl_eval(output int k, output logic [7:0] a, output logic [3:0] m,
                           output logic [1:0] c);
      logic sel, pgo, st;
      logic [1:0] low;
      sel = !en_n && shi && !slo_n;
      pgo = !ps_n && !en_n;
      st  = pgo || !cs_n;
      m   = !gw_n ? 4'hF : (!bwe_n ? ~bw_n : 4'h0);
      k = 0; a = m_base; c = m_cnt;
      if (st && sel) begin
         a = addr; c = 2'd0;
         k = (!pgo && m != 4'h0) ? 2 : 1;
      end else if (st) begin
         k = 0;
      end else if (m_act) begin
         c   = step_n ? m_cnt : m_cnt + 2'd1;
         low = ilv ? (m_base[1:0] ^ c) : (m_base[1:0] + c);
         a   = {m_base[7:2], low};
         k   = (m != 4'h0) ? 2 : 1;
      end
      if (k != 2) m = 4'h0;
   endtask

   task automatic mdl_commit();
      int k; logic [7:0] a; logic [3:0] m; logic [1:0] c;
      logic sel, st;
      if (sleep) return;
      mdl_eval(k, a, m, c);
      sel = !en_n && shi && !slo_n;
      st  = (!ps_n && !en_n) || !cs_n;
      e_valid = m_pend;
      if (m_pend) begin e_d = ref_d[m_paddr]; e_p = ref_p[m_paddr]; end
      if (st && sel) begin m_base = addr; m_cnt = 2'd0; m_act = 1'b1; end
      else if (st) m_act = 1'b0;
      else if (m_act) m_cnt = c;
      m_pend  = (k == 1);
      m_paddr = a;
      for (int l = 0; l < 4; l++) begin
         if (m[l]) begin
            ref_d[a][8*l +: 8] = wd[8*l +: 8];
            ref_p[a][l]        = wp[l];
         end
      end
   endtask

   // one clock with the inputs already set; called just after a falling edge
   task automatic go();
      int k; logic [7:0] a; logic [3:0] m; logic [1:0] c;
      #1;
      mdl_eval(k, a, m, c);
      // R9 drive indication
      chk(out_drive == (e_valid && !oe_n && !sleep && k != 2), (tag == "R11") ? "R9" : tag,
          out_drive, (e_valid && !oe_n && !sleep && k != 2));
      @(posedge clk);
      mdl_commit();
      #1;
      // R6 pipelined valid and data
      chk(rd_valid == e_valid, tag, rd_valid, e_valid);
      if (e_valid) chk({rd_par, rd_data} == {e_p, e_d}, tag, {rd_par, rd_data}, {e_p, e_d});
      @(negedge clk);
   endtask

   task automatic quiet();
      ps_n = 1; cs_n = 1; en_n = 0; shi = 1; slo_n = 0; step_n = 1;
      gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0; sleep = 0;
   endtask

   task automatic deselect();
      quiet(); cs_n = 0; en_n = 1; go(); quiet();
   endtask

   task automatic burst_read(input logic [7:0] a, input bit use_proc, input int steps);
      quiet(); addr = a;
      if (use_proc) ps_n = 0; else cs_n = 0;
      go(); quiet();
      for (int i = 0; i < steps; i++) begin step_n = 0; go(); end
      quiet(); go(); go();
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      summary();
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      quiet(); ilv = 0; addr = 0; wd = 0; wp = 0; rst_n = 0;
      m_base = 0; m_paddr = 0; m_cnt = 0; m_act = 0; m_pend = 0;
      e_valid = 0; e_d = 0; e_p = 0;
      for (int i = 0; i < DEPTH; i++) begin ref_d[i] = 0; ref_p[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      // R11 reset state
      chk(rd_valid == 1'b0, "R11", rd_valid, 0);
      chk(out_drive == 1'b0, "R11", out_drive, 0);
      @(negedge clk);

      // R4 / R2: fill all words with controller-started global writes
      tag = "R4";
      for (int i = 0; i < DEPTH; i++) begin
         quiet(); cs_n = 0; en_n = 1 - 1; gw_n = 0; addr = i[7:0];
         wd = $urandom; wp = $urandom;
         go();
      end
      deselect();

      // R7 linear and interleaved bursts from each offset, wrapping
      tag = "R7";
      for (int o = 0; o < 4; o++) begin
         ilv = 0; burst_read(8'h40 + o[7:0], 0, 5);
         ilv = 1; burst_read(8'h80 + o[7:0], 1, 5);
      end
      ilv = 0;
      deselect();

      // R8 suspend holds the same word for reads
      tag = "R8";
      quiet(); addr = 8'h21; cs_n = 0; go(); quiet();
      go(); go(); step_n = 0; go(); quiet(); go();
      deselect();

      // R3 processor start ignores write controls; next edge writes same word
      tag = "R3";
      quiet(); addr = 8'h09; ps_n = 0; gw_n = 0; wd = 32'hDEAD_BEEF; wp = 4'h5; go();
      quiet(); gw_n = 0; wd = 32'h1234_5678; wp = 4'hA; go();
      quiet(); go(); go();
      deselect();

      // R5 lane writes with gaps, and selects ignored without qualifier
      tag = "R5";
      quiet(); addr = 8'h33; cs_n = 0; bwe_n = 0; bw_n = 4'b1010;
      wd = 32'hA1B2_C3D4; wp = 4'hF; go();
      quiet(); addr = 8'h34; cs_n = 0; bwe_n = 1; bw_n = 4'b0000; wd = 32'h0; go();
      quiet(); addr = 8'h35; cs_n = 0; bwe_n = 0; bw_n = 4'b0101; wd = 32'h5566_7788; wp = 4'h0; go();
      quiet(); addr = 8'h33; cs_n = 0; go();
      quiet(); addr = 8'h35; cs_n = 0; go();
      quiet(); go();
      deselect();

      // R1 deselect through each select; R2 processor strobe gated by enable
      tag = "R1";
      quiet(); addr = 8'h50; cs_n = 0; go();
      quiet(); cs_n = 0; shi = 0; go();
      quiet(); step_n = 0; go(); go();
      quiet(); addr = 8'h54; cs_n = 0; go();
      quiet(); ps_n = 0; slo_n = 1; go();
      quiet(); go();
      tag = "R2";
      quiet(); addr = 8'h60; cs_n = 0; go();
      quiet(); addr = 8'h70; ps_n = 0; en_n = 1; step_n = 0; go();
      quiet(); go(); go();
      deselect();

      // R9 output enable high blocks drive
      tag = "R9";
      quiet(); addr = 8'h11; cs_n = 0; go();
      quiet(); oe_n = 1; go(); go();
      quiet(); gw_n = 0; wd = 32'h0BAD_F00D; go();
      quiet(); go();
      deselect();

      // R10 sleep mid-burst; leave sleep with a deselect cycle
      tag = "R10";
      quiet(); addr = 8'h22; cs_n = 0; go();
      quiet(); step_n = 0; go();
      for (int i = 0; i < 3; i++) begin
         quiet(); sleep = 1; cs_n = 0; gw_n = 0; addr = $urandom; wd = $urandom; step_n = 0;
         go();
      end
      deselect();
      burst_read(8'h22, 0, 3);

      // random mix checked against the reference
      for (int seg = 0; seg < 3; seg++) begin
         tag = (seg == 1) ? "R7" : "R6";
         ilv = (seg == 1);
         for (int i = 0; i < 1000; i++) begin
            int r;
            quiet();
            r = $urandom % 16;
            addr = $urandom; wd = $urandom; wp = $urandom;
            if (r < 3) cs_n = 0;
            else if (r < 5) ps_n = 0;
            else if (r == 5) begin cs_n = 0; en_n = $urandom; shi = $urandom; slo_n = $urandom; end
            else if (r == 6) begin ps_n = 0; en_n = 1; end
            step_n = $urandom;
            gw_n   = ($urandom % 4) != 0;
            bwe_n  = $urandom;
            bw_n   = $urandom;
            oe_n   = ($urandom % 5) == 0;
            go();
         end
         deselect();
      end

      summary();
   end

endmodule